// File: doc/BRIEF.md
# Secure-State Event Dispatch Controller

This block sits next to a processor core and decides what happens to pending events while the core runs in its secure execution state. At power-up it runs a short preload sequence that latches the secure-state flag and the secure-debug permission from fuses, and loads the secure address register from a protected flash word. Until that sequence finishes, no event is accepted and debug stays disabled.

Once boot is done and the secure flag is set, the block watches the exception, NMI, breakpoint, secure-call and four interrupt-level request lines. It applies the global mask and the per-level interrupt masks from the status register and picks one event by fixed priority. It then issues a one-cycle take strobe with a fixed absolute handler address. Taking a secure call also asks the core to set the global mask. When the secure flag is clear, the block never takes a secure vector. Instead it raises a normal-mode flag so the core uses its ordinary vectoring.

Two state machines do the work. The boot machine has the states BOOT_IDLE, BOOT_LOAD and BOOT_DONE. It leaves BOOT_IDLE on the first clock after reset. It stays in BOOT_LOAD for LOAD_CYC cycles and then moves to BOOT_DONE, where it stays. The dispatch machine has the states D_WAIT, D_READY and D_ISSUE. It moves from D_WAIT to D_READY when boot completes. From D_READY it goes to D_ISSUE when a secure, unmasked event is pending. From D_ISSUE it returns to D_READY after one cycle.

Top module: `secure_event_dispatch`

## Requirements
- R1: After reset release, boot_done stays low for LOAD_CYC+1 rising edges and rises at edge LOAD_CYC+1. It then stays high until the next reset. ss_flag, dbg_en, evt_take and normal_mode are all 0 while boot_done is low.
- R2: At the end of the load phase, ss_flag takes the value of fuse_sse and sec_addr takes the value of prot_word. Later changes to fuse_sse, fuse_ssde or prot_word do not change ss_flag, sec_addr or dbg_en.
- R3: Each source has a fixed handler address and a source code on evt_src. Secure call: 0x8000_0004, code 0. NMI: 0x8000_000C, code 2. Breakpoint: 0x8000_0010, code 3. Interrupt level i (0 to 3): 0x8000_0014, code 4+i. All interrupt levels share that one address.
- R4: Any bit of exc_req is taken as an exception with handler address 0x8000_0008 and code 1, whichever cause bit is set.
- R5: When several unmasked events are pending together, the one taken follows this order: exception, then NMI, then breakpoint, then secure call, then interrupt level 3, 2, 1 and 0.
- R6: While gm_in is 1, NMI and all interrupt levels are not taken. Exceptions, breakpoints and secure calls are still taken. With gm_in at 0, NMI is taken.
- R7: Interrupt level i is not taken while irq_mask_in[i] is 1, even when gm_in is 0. The other levels are unaffected.
- R8: gm_set is high in exactly the cycles in which evt_take is high with a secure-call source.
- R9: After boot, dbg_en is 1 if ss_flag is 0. If ss_flag is 1, dbg_en is 1 only when fuse_ssde was 1 at load time.
- R10: With ss_flag at 0 after boot, normal_mode is 1 and no request ever produces evt_take.
- R11: A request seen at a rising edge in D_READY gives evt_take high for exactly the one following cycle, with evt_vector and evt_src valid. evt_take is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fuse_sse | input | 1 | Secure-state enable fuse |
| fuse_ssde | input | 1 | Secure-state debug enable fuse |
| prot_word | input | AW (32) | Protected flash word for the secure address register |
| exc_req | input | NEXC (4) | Exception cause requests |
| nmi_req | input | 1 | NMI request |
| bkpt_req | input | 1 | Breakpoint request |
| scall_req | input | 1 | Secure call request |
| irq_req | input | NIRQ (4) | Interrupt level requests, bit i = level i |
| gm_in | input | 1 | Global mask bit from status register |
| irq_mask_in | input | NIRQ (4) | Per-level interrupt mask bits |
| boot_done | output | 1 | Boot preload complete |
| ss_flag | output | 1 | Secure-state flag |
| sec_addr | output | AW (32) | Secure address register |
| dbg_en | output | 1 | Debug enable |
| normal_mode | output | 1 | Core should use ordinary vectoring |
| evt_take | output | 1 | Take-event strobe |
| evt_src | output | 3 | Source code of taken event |
| evt_vector | output | 32 | Handler address of taken event |
| gm_set | output | 1 | Request to set the global mask |

## Verification
A boot machine that is stuck or leaves early shows up as boot_done rising on the wrong edge. It also shows up as ss_flag or dbg_en taking a value other than the fuse-derived one, and the bench checks these edge by edge right after reset. A dispatch machine that sticks in D_ISSUE or skips it shows up within two cycles of a request, as a take strobe that is missing, too long, or repeated. A wrong arbitration or mask state shows up in the same cycle as the strobe, through the source code and the handler address.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    typedef enum logic [1:0] {
        BOOT_IDLE = 2'd0,
        BOOT_LOAD = 2'd1,
        BOOT_DONE = 2'd2
    } boot_state_t;

    typedef enum logic [1:0] {
        D_WAIT  = 2'd0,
        D_READY = 2'd1,
        D_ISSUE = 2'd2
    } disp_state_t;

    localparam int SRC_W       = 3;
    localparam logic [SRC_W-1:0] SRC_SCALL = 3'd0;
    localparam logic [SRC_W-1:0] SRC_EXC   = 3'd1;
    localparam logic [SRC_W-1:0] SRC_NMI   = 3'd2;
    localparam logic [SRC_W-1:0] SRC_BKPT  = 3'd3;
    localparam logic [SRC_W-1:0] SRC_IRQ0  = 3'd4;

    // Fixed absolute handler address: base + 4*(slot+1), all interrupt levels share slot 4.
    function automatic logic [31:0] handler_addr(input logic [31:0] base,
                                                 input logic [SRC_W-1:0] src);
        logic [31:0] slot;
        slot = (src >= SRC_IRQ0) ? 32'd4 : {29'd0, src};
        return base + ((slot + 32'd1) << 2);
    endfunction

endpackage

// File: rtl/ssd_boot_fsm.sv
module ssd_boot_fsm
    import ssd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LOAD_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fuse_sse,
    input  logic          fuse_ssde,
    input  logic [AW-1:0] prot_word,
    output logic          boot_done,
    output logic          ss_q,
    output logic          ssde_q,
    output logic [AW-1:0] sec_addr_q
);
    localparam int CW = (LOAD_CYC > 1) ? $clog2(LOAD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOAD_CYC - 1);

    boot_state_t    state, state_nx;
    logic [CW-1:0]  cnt;
    logic           load_end;

    assign load_end = (state == BOOT_LOAD) && (cnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            BOOT_IDLE: state_nx = BOOT_LOAD;
            BOOT_LOAD: if (load_end) state_nx = BOOT_DONE;
            BOOT_DONE: state_nx = BOOT_DONE;
            default:   state_nx = BOOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= BOOT_IDLE;
            cnt        <= '0;
            ss_q       <= 1'b0;
            ssde_q     <= 1'b0;
            sec_addr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == BOOT_LOAD && !load_end) cnt <= cnt + 1'b1;
            if (load_end) begin
                ss_q       <= fuse_sse;
                ssde_q     <= fuse_ssde;
                sec_addr_q <= prot_word;
            end
        end
    end

    always_comb begin
        boot_done = (state == BOOT_DONE);
    end
endmodule

// File: rtl/ssd_event_arb.sv
module ssd_event_arb
    import ssd_pkg::*;
#(
    parameter int NEXC = 4,
    parameter int NIRQ = 4
) (
    input  logic                  secure_ok,
    input  logic [NEXC-1:0]       exc_req,
    input  logic                  nmi_req,
    input  logic                  bkpt_req,
    input  logic                  scall_req,
    input  logic [NIRQ-1:0]       irq_req,
    input  logic                  gm_in,
    input  logic [NIRQ-1:0]       irq_mask_in,
    output logic                  cand_valid,
    output logic [SRC_W-1:0]      cand_src
);
    logic [NIRQ-1:0] irq_live;
    logic            nmi_live;

    assign nmi_live = nmi_req & ~gm_in;

    for (genvar g = 0; g < NIRQ; g++) begin : g_irq_gate
        assign irq_live[g] = irq_req[g] & ~irq_mask_in[g] & ~gm_in;
    end

    // Lowest priority first, higher ones override.
    always_comb begin
        cand_valid = 1'b0;
        cand_src   = SRC_SCALL;
        for (int i = 0; i < NIRQ; i++) begin
            if (irq_live[i]) begin
                cand_valid = 1'b1;
                cand_src   = SRC_IRQ0 + SRC_W'(i);
            end
        end
        if (scall_req) begin cand_valid = 1'b1; cand_src = SRC_SCALL; end
        if (bkpt_req)  begin cand_valid = 1'b1; cand_src = SRC_BKPT;  end
        if (nmi_live)  begin cand_valid = 1'b1; cand_src = SRC_NMI;   end
        if (|exc_req)  begin cand_valid = 1'b1; cand_src = SRC_EXC;   end
        if (!secure_ok) cand_valid = 1'b0;
    end
endmodule

// File: rtl/ssd_dispatch_fsm.sv
module ssd_dispatch_fsm
    import ssd_pkg::*;
#(
    parameter logic [31:0] VEC_BASE = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_done,
    input  logic             cand_valid,
    input  logic [SRC_W-1:0] cand_src,
    output logic             take,
    output logic [SRC_W-1:0] src,
    output logic [31:0]      vector,
    output logic             gm_set
);
    disp_state_t      state, state_nx;
    logic [SRC_W-1:0] src_q;
    logic [31:0]      vec_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            D_WAIT:  if (boot_done) state_nx = D_READY;
            D_READY: if (cand_valid) state_nx = D_ISSUE;
            D_ISSUE: state_nx = D_READY;
            default: state_nx = D_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= D_WAIT;
            src_q <= '0;
            vec_q <= '0;
        end else begin
            state <= state_nx;
            if (state == D_READY && cand_valid) begin
                src_q <= cand_src;
                vec_q <= handler_addr(VEC_BASE, cand_src);
            end
        end
    end

    always_comb begin
        take   = (state == D_ISSUE);
        src    = take ? src_q : '0;
        vector = take ? vec_q : '0;
        gm_set = take && (src_q == SRC_SCALL);
    end
endmodule

// File: rtl/secure_event_dispatch.sv
module secure_event_dispatch
    import ssd_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          NEXC     = 4,
    parameter int          NIRQ     = 4,
    parameter int          LOAD_CYC = 4,
    parameter logic [31:0] VEC_BASE = 32'h8000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fuse_sse,
    input  logic             fuse_ssde,
    input  logic [AW-1:0]    prot_word,
    input  logic [NEXC-1:0]  exc_req,
    input  logic             nmi_req,
    input  logic             bkpt_req,
    input  logic             scall_req,
    input  logic [NIRQ-1:0]  irq_req,
    input  logic             gm_in,
    input  logic [NIRQ-1:0]  irq_mask_in,
    output logic             boot_done,
    output logic             ss_flag,
    output logic [AW-1:0]    sec_addr,
    output logic             dbg_en,
    output logic             normal_mode,
    output logic             evt_take,
    output logic [2:0]       evt_src,
    output logic [31:0]      evt_vector,
    output logic             gm_set
);
    logic             ssde_q;
    logic             cand_valid;
    logic [SRC_W-1:0] cand_src;

    ssd_boot_fsm #(.AW(AW), .LOAD_CYC(LOAD_CYC)) u_boot (
        .clk(clk), .rst_n(rst_n),
        .fuse_sse(fuse_sse), .fuse_ssde(fuse_ssde), .prot_word(prot_word),
        .boot_done(boot_done), .ss_q(ss_flag), .ssde_q(ssde_q), .sec_addr_q(sec_addr)
    );

    ssd_event_arb #(.NEXC(NEXC), .NIRQ(NIRQ)) u_arb (
        .secure_ok(boot_done & ss_flag),
        .exc_req(exc_req), .nmi_req(nmi_req), .bkpt_req(bkpt_req),
        .scall_req(scall_req), .irq_req(irq_req),
        .gm_in(gm_in), .irq_mask_in(irq_mask_in),
        .cand_valid(cand_valid), .cand_src(cand_src)
    );

    ssd_dispatch_fsm #(.VEC_BASE(VEC_BASE)) u_disp (
        .clk(clk), .rst_n(rst_n), .boot_done(boot_done),
        .cand_valid(cand_valid), .cand_src(cand_src),
        .take(evt_take), .src(evt_src), .vector(evt_vector), .gm_set(gm_set)
    );

    assign dbg_en      = boot_done & (~ss_flag | ssde_q);
    assign normal_mode = boot_done & ~ss_flag;
endmodule

// File: rtl/ssd_chk.sv
module ssd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        boot_done,
    input logic        ss_flag,
    input logic        dbg_en,
    input logic        normal_mode,
    input logic        evt_take,
    input logic [2:0]  evt_src,
    input logic [31:0] evt_vector,
    input logic        gm_set,
    input logic        nmi_req,
    input logic        gm_in
);
    // R1
    boot_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);
    // R1
    no_early_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done |-> (!dbg_en && !ss_flag && !evt_take));
    // R8
    gm_set_only_scall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gm_set |-> (evt_take && evt_src == 3'd0));
    // R8
    scall_sets_gm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_take && evt_src == 3'd0) |-> gm_set);
    // R10
    take_needs_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> (ss_flag && !normal_mode));
    // R11
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |=> !evt_take);
    // R3
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> (evt_vector[31:8] == 24'h800000 && evt_vector[7:0] >= 8'h04 && evt_vector[7:0] <= 8'h14));
    // R6
    nmi_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_take && evt_src == 3'd2) |-> ($past(nmi_req) && !$past(gm_in)));
endmodule

bind secure_event_dispatch ssd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done), .ss_flag(ss_flag),
    .dbg_en(dbg_en), .normal_mode(normal_mode), .evt_take(evt_take),
    .evt_src(evt_src), .evt_vector(evt_vector), .gm_set(gm_set),
    .nmi_req(nmi_req), .gm_in(gm_in)
);

// File: tb/sim_secure_event_dispatch.sv
module sim_secure_event_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int LOAD_CYC   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fuse_sse = 1'b0, fuse_ssde = 1'b0;
    logic [31:0] prot_word = '0;
    logic [3:0]  exc_req = '0;
    logic        nmi_req = 1'b0, bkpt_req = 1'b0, scall_req = 1'b0;
    logic [3:0]  irq_req = '0;
    logic        gm_in = 1'b0;
    logic [3:0]  irq_mask_in = '0;
    logic        boot_done, ss_flag, dbg_en, normal_mode, evt_take, gm_set;
    logic [31:0] sec_addr, evt_vector;
    logic [2:0]  evt_src;

    int n_chk = 0, n_bad = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secure_event_dispatch #(.LOAD_CYC(LOAD_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .fuse_sse(fuse_sse), .fuse_ssde(fuse_ssde),
        .prot_word(prot_word), .exc_req(exc_req), .nmi_req(nmi_req),
        .bkpt_req(bkpt_req), .scall_req(scall_req), .irq_req(irq_req),
        .gm_in(gm_in), .irq_mask_in(irq_mask_in), .boot_done(boot_done),
        .ss_flag(ss_flag), .sec_addr(sec_addr), .dbg_en(dbg_en),
        .normal_mode(normal_mode), .evt_take(evt_take), .evt_src(evt_src),
        .evt_vector(evt_vector), .gm_set(gm_set)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_vec(input int code);
        case (code)
            0: return 32'h8000_0004;
            1: return 32'h8000_0008;
            2: return 32'h8000_000C;
            3: return 32'h8000_0010;
            default: return 32'h8000_0014;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic clear_reqs();
        exc_req = '0; nmi_req = 0; bkpt_req = 0; scall_req = 0; irq_req = '0;
    endtask

    // Reset, run boot, check timing and latched values.
    task automatic t_reset_boot(input logic sse, input logic ssde, input logic [31:0] word);
        @(negedge clk);
        rst_n = 0; fuse_sse = sse; fuse_ssde = ssde; prot_word = word;
        clear_reqs(); gm_in = 0; irq_mask_in = '0;
        tick(); tick();
        check("R1 reset boot_done", {31'd0, boot_done}, 0);
        check("R1 reset take", {31'd0, evt_take}, 0);
        rst_n = 1;
        for (int k = 1; k <= LOAD_CYC; k++) begin
            tick();
            check("R1 boot_done low during load", {31'd0, boot_done}, 0);
            check("R1 dbg_en low during load", {31'd0, dbg_en}, 0);
        end
        tick();
        check("R1 boot_done rises", {31'd0, boot_done}, 1);
        check("R2 ss_flag from fuse", {31'd0, ss_flag}, {31'd0, sse});
        check("R2 sec_addr loaded", sec_addr, word);
        check("R9 dbg_en", {31'd0, dbg_en}, {31'd0, (~sse) | ssde});
        tick(); // dispatch machine reaches D_READY
    endtask

    task automatic fire(input string req, input logic [3:0] exc, input logic nmi,
                        input logic bkpt, input logic sc, input logic [3:0] irq,
                        input logic exp_take, input int exp_src);
        exc_req = exc; nmi_req = nmi; bkpt_req = bkpt; scall_req = sc; irq_req = irq;
        tick();
        clear_reqs();
        check({req, " take"}, {31'd0, evt_take}, {31'd0, exp_take});
        if (exp_take) begin
            check({req, " src"}, {29'd0, evt_src}, exp_src);
            check({req, " vector"}, evt_vector, exp_vec(exp_src));
            check({req, " R8 gm_set"}, {31'd0, gm_set}, {31'd0, exp_src == 0});
        end
        tick();
        check({req, " R11 strobe ends"}, {31'd0, evt_take}, 0);
    endtask

    task automatic t_vectors();
        fire("R3 scall", 0, 0, 0, 1, 0, 1, 0);
        fire("R3 nmi", 0, 1, 0, 0, 0, 1, 2);
        fire("R3 bkpt", 0, 0, 1, 0, 0, 1, 3);
        for (int i = 0; i < 4; i++) fire("R3 irq", 0, 0, 0, 0, 4'(1 << i), 1, 4 + i);
        for (int i = 0; i < 4; i++) fire("R4 exc cause", 4'(1 << i), 0, 0, 0, 0, 1, 1);
    endtask

    task automatic t_priority();
        fire("R5 all", 4'b0100, 1, 1, 1, 4'hF, 1, 1);
        fire("R5 nmi over bkpt", 0, 1, 1, 1, 4'hF, 1, 2);
        fire("R5 bkpt over scall", 0, 0, 1, 1, 4'hF, 1, 3);
        fire("R5 scall over irq", 0, 0, 0, 1, 4'hF, 1, 0);
        fire("R5 irq3 top", 0, 0, 0, 0, 4'b1001, 1, 7);
        fire("R5 irq2 over 1", 0, 0, 0, 0, 4'b0110, 1, 6);
        fire("R5 irq1 over 0", 0, 0, 0, 0, 4'b0011, 1, 5);
    endtask

    task automatic t_gm_mask();
        gm_in = 1;
        fire("R6 nmi masked", 0, 1, 0, 0, 0, 0, 0);
        fire("R6 irq masked", 0, 0, 0, 0, 4'hF, 0, 0);
        fire("R6 exc passes gm", 4'b0001, 1, 0, 0, 0, 1, 1);
        fire("R6 scall passes gm", 0, 1, 0, 1, 4'hF, 1, 0);
        fire("R6 bkpt passes gm", 0, 1, 1, 0, 0, 1, 3);
        gm_in = 0;
        fire("R6 nmi after clear", 0, 1, 0, 0, 0, 1, 2);
    endtask

    task automatic t_level_mask();
        irq_mask_in = 4'b1000;
        fire("R7 irq3 masked", 0, 0, 0, 0, 4'b1000, 0, 0);
        fire("R7 irq2 unaffected", 0, 0, 0, 0, 4'b1100, 1, 6);
        irq_mask_in = 4'b0111;
        fire("R7 low levels masked", 0, 0, 0, 0, 4'b0111, 0, 0);
        irq_mask_in = '0;
        fire("R7 unmasked level0", 0, 0, 0, 0, 4'b0001, 1, 4);
    endtask

    task automatic t_fuse_ignored(input logic sse, input logic ssde, input logic [31:0] word);
        fuse_sse = ~sse; fuse_ssde = ~ssde; prot_word = ~word;
        tick(); tick();
        check("R2 ss_flag holds", {31'd0, ss_flag}, {31'd0, sse});
        check("R2 sec_addr holds", sec_addr, word);
        check("R2 dbg_en holds", {31'd0, dbg_en}, {31'd0, (~sse) | ssde});
    endtask

    task automatic t_normal();
        check("R10 normal_mode", {31'd0, normal_mode}, 1);
        fire("R10 exc ignored", 4'hF, 0, 0, 0, 0, 0, 0);
        fire("R10 all ignored", 4'hF, 1, 1, 1, 4'hF, 0, 0);
        tick();
        check("R10 no late take", {31'd0, evt_take}, 0);
    endtask

    initial begin
        // Secure, no debug
        t_reset_boot(1, 0, 32'h1234_5678);
        check("R10 normal_mode off in secure", {31'd0, normal_mode}, 0);
        t_vectors();
        t_priority();
        t_gm_mask();
        t_level_mask();
        t_fuse_ignored(1, 0, 32'h1234_5678);
        // Secure with debug fuse
        t_reset_boot(1, 1, 32'hCAFE_0042);
        t_fuse_ignored(1, 1, 32'hCAFE_0042);
        // Not secure
        t_reset_boot(0, 0, 32'h0000_BEEF);
        check("R9 debug in normal", {31'd0, dbg_en}, 1);
        t_normal();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule